// File: doc/BRIEF.md
# Stack-Depth Operand Block Detector

This monitor sits beside a stack-machine pipeline and watches each executed instruction as it retires: its program address, its operation class, the stack pointer before and after it, and the address that follows it. It looks for runs of dependent instructions that leave the stack at the same depth where they began. Such a run is a self-contained operand block that a combinational array could execute in one step. The detector has no ready or stall output, so it never holds the pipeline back.

When a run closes, is long enough to be worth accelerating, and starts at an address not seen before, the detector raises a one-cycle capture request. The request carries the start address, the instruction count and the address after the last instruction. A configuration store uses the start address as its key, so the next time the pipeline reaches that address it can send the run to the array. Only the stack pointer marks block boundaries. Control flow is not analysed. Instructions the array cannot handle end the current candidate.

Top module: `odd_block_detector`

## Requirements
- R1: After reset, `cap_valid` is low, and it stays low until a qualifying block closes.
- R2: If no candidate is open, a supported instruction (`ins_cls` 0 to 4) opens one. That instruction's address becomes the block's start address, and its `ins_sp_pre` becomes the reference depth.
- R3: A candidate closes on the first instruction whose `ins_sp_post` equals the reference depth. If the block qualifies, `cap_valid` is high for exactly one cycle in the cycle after the closing instruction is sampled. In that cycle `cap_start_pc` is the start address, `cap_len` is the instruction count including the closing instruction, and `cap_next_pc` is the `ins_next_pc` of the closing instruction.
- R4: A closed block with fewer than MIN_LEN instructions (default 3) is dropped without a request. The detector is then idle.
- R5: An instruction of class 5 (call), 6 (return) or 7 (unsupported) discards any open candidate without a request. The next supported instruction opens a new candidate.
- R6: A closed block whose start address is already held in the seen-address table is not reported again.
- R7: Cycles with `ins_valid` low leave the candidate, its count and its reference depth unchanged.
- R8: A candidate whose count reaches MAX_LEN (default 16) without closing is discarded. A block that closes at exactly MAX_LEN instructions is still reported. The instruction after a discard opens a new candidate.
- R9: The seen-address table holds TAB_DEPTH (default 4) addresses and replaces the oldest one on each new report. After TAB_DEPTH newer reports, an address can be reported again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | A retired instruction is presented this cycle |
| ins_pc | input | PC_W | Address of the instruction |
| ins_cls | input | 3 | Operation class: 0 alu, 1 shift, 2 memory, 3 multiply, 4 push, 5 call, 6 return, 7 unsupported |
| ins_sp_pre | input | SP_W | Stack pointer before the instruction |
| ins_sp_post | input | SP_W | Stack pointer after the instruction |
| ins_next_pc | input | PC_W | Address that follows the instruction |
| cap_valid | output | 1 | One-cycle capture request |
| cap_start_pc | output | PC_W | Start address of the captured block |
| cap_len | output | LEN_W | Instruction count of the captured block |
| cap_next_pc | output | PC_W | Address following the captured block |

## Verification
On every cycle, the assertions check the following:
- a closing instruction ends the candidate and a fresh one opens it;
- an idle cycle leaves the tracker frozen;
- an unsupported class clears the candidate and never coincides with a request;
- every request carries a length between MIN_LEN and MAX_LEN;
- the table never loses occupancy.

Only the directed scenarios can show the rest:
- that the reported address, length and next address match the right instructions;
- that duplicate start addresses are suppressed;
- that the oldest entry is evicted in order;
- that a run is discarded exactly at the length limit.

// File: rtl/odd_pkg.sv
package odd_pkg;
  typedef enum logic [2:0] {
    CLS_ALU    = 3'd0,
    CLS_SHIFT  = 3'd1,
    CLS_MEM    = 3'd2,
    CLS_MUL    = 3'd3,
    CLS_PUSH   = 3'd4,
    CLS_CALL   = 3'd5,
    CLS_RET    = 3'd6,
    CLS_OTHER  = 3'd7
  } op_cls_e;

  // classes the array can absorb
  function automatic logic op_supported(input logic [2:0] cls);
    return cls <= 3'(CLS_PUSH);
  endfunction

  // depth-neutral test used for block closing
  function automatic logic depth_match(input logic [15:0] a, input logic [15:0] b);
    return a == b;
  endfunction
endpackage

// File: rtl/odd_tracker.sv
module odd_tracker
  import odd_pkg::*;
#(
  parameter int PC_W    = 16,
  parameter int SP_W    = 8,
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic [PC_W-1:0]  ins_pc,
  input  logic [2:0]       ins_cls,
  input  logic [SP_W-1:0]  ins_sp_pre,
  input  logic [SP_W-1:0]  ins_sp_post,
  output logic             ev_start,
  output logic             ev_close,
  output logic             ev_abort,
  output logic [PC_W-1:0]  close_pc,
  output logic [LEN_W-1:0] close_len
);
  localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] ONE   = LEN_W'(1);

  logic             active;
  logic [PC_W-1:0]  start_pc;
  logic [SP_W-1:0]  start_sp;
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] len_nx;
  logic             sup, closes_fresh, closes_run;

  assign sup          = op_supported(ins_cls);
  assign closes_fresh = depth_match(16'(ins_sp_post), 16'(ins_sp_pre));
  assign closes_run   = depth_match(16'(ins_sp_post), 16'(start_sp));
  assign len_nx       = len + ONE;

  always_comb begin
    ev_start  = 1'b0;
    ev_close  = 1'b0;
    ev_abort  = 1'b0;
    close_pc  = active ? start_pc : ins_pc;
    close_len = active ? len_nx : ONE;
    if (ins_valid) begin
      if (!sup) begin
        ev_abort = active;
      end else if (!active) begin
        ev_start = 1'b1;
        ev_close = closes_fresh;
      end else if (closes_run) begin
        ev_close = 1'b1;
      end else if (len_nx >= LIMIT) begin
        ev_abort = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      start_pc <= '0;
      start_sp <= '0;
      len      <= '0;
    end else if (ins_valid) begin
      if (!sup) begin
        active <= 1'b0;
      end else if (!active) begin
        start_pc <= ins_pc;
        start_sp <= ins_sp_pre;
        len      <= ONE;
        active   <= !closes_fresh && (MAX_LEN > 1);
      end else if (closes_run || len_nx >= LIMIT) begin
        active <= 1'b0;
      end else begin
        len <= len_nx;
      end
    end
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> $stable(active) && $stable(len) && $stable(start_sp));

  // R5
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !sup |=> !active);

  // R3
  close_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && ins_valid && sup && (ins_sp_post == start_sp) |=> !active);

  // R2
  open_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active && ins_valid && sup && (ins_sp_post != ins_sp_pre) |=> active && (len == ONE));
endmodule

// File: rtl/odd_seen_table.sv
module odd_seen_table #(
  parameter int PC_W      = 16,
  parameter int TAB_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] look_pc,
  output logic            hit,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc
);
  localparam int PTR_W = (TAB_DEPTH > 1) ? $clog2(TAB_DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(TAB_DEPTH - 1);

  logic [PC_W-1:0]      addr_q [TAB_DEPTH];
  logic [TAB_DEPTH-1:0] vld_q;
  logic [TAB_DEPTH-1:0] match;
  logic [PTR_W-1:0]     wptr;

  for (genvar g = 0; g < TAB_DEPTH; g++) begin : g_ent
    assign match[g] = vld_q[g] && (addr_q[g] == look_pc);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g]  <= 1'b0;
        addr_q[g] <= '0;
      end else if (wr_en && (wptr == PTR_W'(g))) begin
        vld_q[g]  <= 1'b1;
        addr_q[g] <= wr_pc;
      end
    end
  end

  assign hit = |match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wptr <= '0;
    else if (wr_en) wptr <= (wptr == LAST) ? '0 : wptr + PTR_W'(1);
  end

  // R9
  occupancy_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> $countones(vld_q) >= $countones($past(vld_q)) && $countones(vld_q) >= 1);

  // R6
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(match) <= 1);
endmodule

// File: rtl/odd_block_detector.sv
module odd_block_detector
  import odd_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int SP_W      = 8,
  parameter int MIN_LEN   = 3,
  parameter int MAX_LEN   = 16,
  parameter int TAB_DEPTH = 4,
  parameter int LEN_W     = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic [PC_W-1:0]  ins_pc,
  input  logic [2:0]       ins_cls,
  input  logic [SP_W-1:0]  ins_sp_pre,
  input  logic [SP_W-1:0]  ins_sp_post,
  input  logic [PC_W-1:0]  ins_next_pc,
  output logic             cap_valid,
  output logic [PC_W-1:0]  cap_start_pc,
  output logic [LEN_W-1:0] cap_len,
  output logic [PC_W-1:0]  cap_next_pc
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  logic             ev_start, ev_close, ev_abort;
  logic [PC_W-1:0]  close_pc;
  logic [LEN_W-1:0] close_len;
  logic             tab_hit, qualify;

  odd_tracker #(.PC_W(PC_W), .SP_W(SP_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) trk_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_pc(ins_pc),
    .ins_cls(ins_cls), .ins_sp_pre(ins_sp_pre), .ins_sp_post(ins_sp_post),
    .ev_start(ev_start), .ev_close(ev_close), .ev_abort(ev_abort),
    .close_pc(close_pc), .close_len(close_len)
  );

  odd_seen_table #(.PC_W(PC_W), .TAB_DEPTH(TAB_DEPTH)) tab_i (
    .clk(clk), .rst_n(rst_n), .look_pc(close_pc), .hit(tab_hit),
    .wr_en(qualify), .wr_pc(close_pc)
  );

  assign qualify = ev_close && (close_len >= MIN_L) && !tab_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid    <= 1'b0;
      cap_start_pc <= '0;
      cap_len      <= '0;
      cap_next_pc  <= '0;
    end else begin
      cap_valid <= qualify;
      if (qualify) begin
        cap_start_pc <= close_pc;
        cap_len      <= close_len;
        cap_next_pc  <= ins_next_pc;
      end
    end
  end

  // R4
  min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> cap_len >= MIN_L);

  // R8
  max_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |-> cap_len <= MAX_L);

  // R5
  abort_no_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> !cap_valid);

  // R2
  start_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |-> !ev_abort);
endmodule

// File: tb/odd_block_detector_tb_top.sv
`timescale 1ns/1ps
module odd_block_detector_tb_top;
  localparam int PC_W = 16, SP_W = 8, LEN_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 1'b0;
  logic [PC_W-1:0] ins_pc = '0, ins_next_pc = '0;
  logic [2:0] ins_cls = '0;
  logic [SP_W-1:0] ins_sp_pre = '0, ins_sp_post = '0;
  logic cap_valid;
  logic [PC_W-1:0] cap_start_pc, cap_next_pc;
  logic [LEN_W-1:0] cap_len;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  odd_block_detector dut_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_pc(ins_pc),
    .ins_cls(ins_cls), .ins_sp_pre(ins_sp_pre), .ins_sp_post(ins_sp_post),
    .ins_next_pc(ins_next_pc), .cap_valid(cap_valid), .cap_start_pc(cap_start_pc),
    .cap_len(cap_len), .cap_next_pc(cap_next_pc)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // present one instruction, return after the edge that samples it
  task automatic issue(input int pc, input int cls, input int pre, input int post);
    @(negedge clk);
    ins_valid = 1'b1; ins_pc = PC_W'(pc); ins_cls = 3'(cls);
    ins_sp_pre = SP_W'(pre); ins_sp_post = SP_W'(post); ins_next_pc = PC_W'(pc + 1);
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ins_valid = 1'b0; ins_cls = 3'd7; ins_sp_post = 8'd40; ins_sp_pre = 8'd99;
      @(posedge clk); #1;
      chk(!cap_valid, "R7 idle no request", cap_valid, 0);
    end
  endtask

  task automatic expect_cap(input string req, input int spc, input int len, input int npc);
    chk(cap_valid, req, cap_valid, 1);
    chk(cap_start_pc == PC_W'(spc), req, cap_start_pc, spc);
    chk(cap_len == LEN_W'(len), req, cap_len, len);
    chk(cap_next_pc == PC_W'(npc), req, cap_next_pc, npc);
  endtask

  // 3-instruction block at pc, base depth sp
  task automatic blk3(input int pc, input int sp);
    issue(pc, 4, sp, sp + 1);
    issue(pc + 1, 4, sp + 1, sp + 2);
    issue(pc + 2, 0, sp + 2, sp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; repeat (3) @(posedge clk); #1;
    chk(!cap_valid, "R1 reset", cap_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!cap_valid, "R1 after reset", cap_valid, 0);
  endtask

  task automatic t_basic();
    issue('h100, 4, 10, 11); chk(!cap_valid, "R2 open", cap_valid, 0);
    issue('h101, 4, 11, 12); chk(!cap_valid, "R3 not yet", cap_valid, 0);
    issue('h102, 3, 12, 11); chk(!cap_valid, "R3 not yet", cap_valid, 0);
    issue('h103, 1, 11, 10); expect_cap("R3 close len4", 'h100, 4, 'h104);
    issue('h200, 4, 10, 11); chk(!cap_valid, "R3 one-cycle pulse", cap_valid, 0);
    issue('h201, 2, 11, 10); chk(!cap_valid, "R4 len2 dropped", cap_valid, 0);
  endtask

  task automatic t_short();
    issue('h210, 0, 20, 20); chk(!cap_valid, "R4 len1 dropped", cap_valid, 0);
    blk3('h220, 20); expect_cap("R4 len3 reported", 'h220, 3, 'h223);
  endtask

  task automatic t_abort();
    issue('h300, 4, 30, 31);
    issue('h301, 5, 31, 32); chk(!cap_valid, "R5 call abort", cap_valid, 0);
    issue('h302, 0, 32, 31); chk(!cap_valid, "R5 new open", cap_valid, 0);
    issue('h303, 6, 31, 30); chk(!cap_valid, "R5 return abort", cap_valid, 0);
    // would have closed old candidate (depth 30) if abort ignored
    blk3('h310, 30); expect_cap("R5 restart", 'h310, 3, 'h313);
    issue('h320, 4, 30, 31); issue('h321, 7, 31, 30);
    chk(!cap_valid, "R5 unsupported abort", cap_valid, 0);
  endtask

  task automatic t_dup();
    blk3('h400, 50); expect_cap("R6 first", 'h400, 3, 'h403);
    blk3('h400, 50); chk(!cap_valid, "R6 duplicate", cap_valid, 0);
  endtask

  task automatic t_gap();
    issue('h500, 4, 40, 41);
    idle(3);
    issue('h501, 4, 41, 42);
    issue('h502, 0, 42, 40); expect_cap("R7 gap ignored", 'h500, 3, 'h503);
  endtask

  task automatic t_maxlen();
    for (int i = 0; i < 16; i++) begin
      issue('h600 + i, 4, 60 + i, 61 + i);
      chk(!cap_valid, "R8 no report while growing", cap_valid, 0);
    end
    // candidate discarded at 16; next opens with depth 76
    issue('h610, 0, 76, 75);
    issue('h611, 0, 75, 60); chk(!cap_valid, "R8 old depth gone", cap_valid, 0);
    issue('h612, 4, 60, 76); expect_cap("R8 restart after discard", 'h610, 3, 'h613);
    for (int i = 0; i < 15; i++) issue('h700 + i, 4, 80 + i, 81 + i);
    issue('h70f, 0, 95, 80); expect_cap("R8 close at max", 'h700, 16, 'h710);
  endtask

  task automatic t_evict();
    for (int i = 0; i < 5; i++) begin
      blk3('h800 + 16 * i, 100); expect_cap("R9 fill", 'h800 + 16 * i, 3, 'h803 + 16 * i);
    end
    blk3('h840, 100); chk(!cap_valid, "R9 recent kept", cap_valid, 0);
    blk3('h800, 100); expect_cap("R9 oldest evicted", 'h800, 3, 'h803);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_short();
    t_abort();
    t_dup();
    t_gap();
    t_maxlen();
    t_evict();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule